// File: doc/BRIEF.md
# Frequency Select and Watchdog Recovery

This block picks the frequency that a clock synthesizer runs at and guards that choice with a watchdog. At the first assertion of the active-low power-good input it captures three frequency strap pins and two output-routing straps. It then merges the captured straps with software selections: a 5-bit table code, a software-select enable and a step-less (M/N synthesis) enable. Its outputs are the active 5-bit table index, an M/N-mode flag, and readback of the straps and watchdog status.

The watchdog is armed by setting its enable and then writing a 7-bit timeout count. Each count unit is one pulse of `tick_250ms`, a single-cycle tick that stands for 250 ms. When the count runs out, the block rewrites the active selection. It loads a programmed safe code if the safe enable is set, and otherwise falls back to the strapped pins. It also clears step-less mode and holds an open-drain reset low for one tick period.

The watchdog state machine has three states. WD_IDLE moves to WD_ARMED on an enable write of 1. WD_ARMED moves to WD_COUNT on a count write, or back to WD_IDLE on an enable write of 0. WD_COUNT stays in WD_COUNT on a count write, moves to WD_IDLE on an enable write of 0, and moves to WD_IDLE with an expiry on a tick when the count is 1 or less. The reset generator moves from RP_RELEASE to RP_HOLD on expiry, and from RP_HOLD back to RP_RELEASE when its tick budget is spent. The strap capture machine moves from CAP_WAIT to CAP_DONE once, at the first cycle in which power-good is low.

Top module: `fsel_wdog_top`

## Requirements
- R1: The strap values are captured in the first cycle after reset in which `pwrgd_n` is 0. They read back on `latched_fs`, and `strap_done` goes to 1. Later changes of the pins or of `pwrgd_n` have no effect on them.
- R2: With the software-select enable at 0, `table_idx` equals {2'b00, latched_fs}. With it at 1, `table_idx` equals the 5-bit software code. Both values are loaded by a `sel_wr` pulse.
- R3: `mn_mode` equals the step-less bit loaded by `sel_wr`. It overrides table selection regardless of the table index.
- R4: `c24_sel` and `pair5_cpu` are 0 out of reset and take the strap pin values at capture. A `c24_wr` or `pair5_wr` pulse overwrites them afterward.
- R5: An enable write of 1 makes `wd_running` 1, but the count does not move until a count write. A count write while the watchdog is disabled loads `wd_count` without starting it.
- R6: While counting, each tick lowers `wd_count` by one, and `wd_running` reads 1. The count reset value is 8.
- R7: A tick when the count is 1 or less ends counting. After that tick `wd_count` is 0, `wd_running` is 0 and `wd_expired` is 1, and the flag stays sticky until the next count write that starts counting.
- R8: A count write while armed or counting reloads the count and clears `wd_expired`. A count write in the same cycle as a tick wins over the decrement.
- R9: Expiry clears `mn_mode`. With `safe_en` at 1 it makes `table_idx` equal `safe_code` by setting the software-select enable.
- R10: Expiry with `safe_en` at 0 clears the software-select enable, so `table_idx` returns to {2'b00, latched_fs}.
- R11: `rst_pull_low` is 1 from the cycle after expiry until RST_TICKS further ticks have been seen (default 1), then returns to 0.
- R12: When expiry and a `sel_wr` pulse fall in the same cycle, the expiry result is what takes effect.
- R13: An enable write of 0 stops the watchdog. `wd_running` goes to 0 and `wd_count` holds its value through later ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| pwrgd_n | input | 1 | Active-low power-good strobe for strap capture |
| strap_fsel | input | 3 | Frequency strap pins |
| strap_pair5 | input | 1 | Strap: spare pair carries a CPU clock (1) or a PCIe lane (0) |
| strap_c24 | input | 1 | Strap: 24 MHz (1) or 48 MHz (0) on the shared output |
| tick_250ms | input | 1 | Single-cycle 250 ms time base |
| sel_wr | input | 1 | Load the selection fields |
| sel_code | input | 5 | Software table code |
| sel_sw_en | input | 1 | Software-select enable value |
| sel_stepless | input | 1 | Step-less enable value |
| safe_en | input | 1 | Use safe code on expiry |
| safe_code | input | 5 | Safe table code |
| wd_en_wr | input | 1 | Watchdog enable write strobe |
| wd_en_val | input | 1 | Watchdog enable value |
| wd_cnt_wr | input | 1 | Timeout count write strobe |
| wd_cnt_val | input | 7 | Timeout count value |
| c24_wr | input | 1 | Write strobe for the 24/48 select |
| c24_val | input | 1 | 24/48 select value |
| pair5_wr | input | 1 | Write strobe for the spare-pair select |
| pair5_val | input | 1 | Spare-pair select value |
| table_idx | output | 5 | Active frequency table index |
| mn_mode | output | 1 | M/N synthesis active |
| latched_fs | output | 3 | Captured frequency straps |
| strap_done | output | 1 | Straps have been captured |
| wd_running | output | 1 | Watchdog enable readback |
| wd_count | output | 7 | Live timeout count |
| wd_expired | output | 1 | Sticky timeout flag |
| rst_pull_low | output | 1 | Open-drain reset: 1 pulls the line low |
| c24_sel | output | 1 | 24/48 select |
| pair5_cpu | output | 1 | Spare-pair select |

## Verification
Watchdog expiry can fall in the same cycle as a software selection write. The bench arranges a count of 1 and raises the tick and `sel_wr` together with a different code and step-less set. It then judges that the index equals the safe code, that M/N mode is off and that the reset pull has started (R12). A count write can also coincide with a tick. That case is provoked mid-count and judged by the count equalling the written value, not that value minus one (R8).

// File: rtl/fsel_pkg.sv
package fsel_pkg;
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_COUNT = 2'd2
    } wd_state_t;

    typedef enum logic {
        RP_RELEASE = 1'b0,
        RP_HOLD    = 1'b1
    } rp_state_t;

    typedef enum logic {
        CAP_WAIT = 1'b0,
        CAP_DONE = 1'b1
    } cap_state_t;
endpackage

// File: rtl/fsel_strap.sv
module fsel_strap
    import fsel_pkg::*;
#(
    parameter int FS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwrgd_n,
    input  logic [FS_W-1:0] pins,
    output logic            capture,
    output logic            done,
    output logic [FS_W-1:0] latched
);
    cap_state_t st, st_nxt;

    always_comb begin
        st_nxt  = st;
        capture = 1'b0;
        unique case (st)
            CAP_WAIT: if (!pwrgd_n) begin
                st_nxt  = CAP_DONE;
                capture = 1'b1;
            end
            CAP_DONE: st_nxt = CAP_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CAP_WAIT;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       latched <= '0;
        else if (capture) latched <= pins;
    end

    assign done = (st == CAP_DONE);

    // R1
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAP_DONE) |=> $stable(latched));
endmodule

// File: rtl/fsel_wdog.sv
module fsel_wdog
    import fsel_pkg::*;
#(
    parameter int CNT_W   = 7,
    parameter int CNT_RST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en_wr,
    input  logic             en_val,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_val,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wd_state_t st, st_nxt;
    logic      stop_req;

    assign stop_req = en_wr && !en_val;

    always_comb begin
        st_nxt = st;
        expire = 1'b0;
        unique case (st)
            WD_IDLE:  if (en_wr && en_val) st_nxt = WD_ARMED;
            WD_ARMED: begin
                if (stop_req)    st_nxt = WD_IDLE;
                else if (cnt_wr) st_nxt = WD_COUNT;
            end
            WD_COUNT: begin
                if (stop_req)    st_nxt = WD_IDLE;
                else if (cnt_wr) st_nxt = WD_COUNT;
                else if (tick && count <= ONE) begin
                    st_nxt = WD_IDLE;
                    expire = 1'b1;
                end
            end
            default: st_nxt = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= WD_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= CNT_W'(CNT_RST);
            flag  <= 1'b0;
        end else begin
            if (cnt_wr)
                count <= cnt_val;
            else if (st == WD_COUNT && tick && !stop_req)
                count <= (count <= ONE) ? '0 : count - ONE;
            if (expire)
                flag <= 1'b1;
            else if (cnt_wr && !stop_req && st != WD_IDLE)
                flag <= 1'b0;
        end
    end

    always_comb running = (st != WD_IDLE);

    // R6
    count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_COUNT && !cnt_wr) |=> (count <= $past(count)));
    // R7
    expire_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (flag && !running && count == '0));
    // R13
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !cnt_wr) |=> (!running && count == $past(count)));
endmodule

// File: rtl/fsel_rstgen.sv
module fsel_rstgen
    import fsel_pkg::*;
#(
    parameter int HOLD_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic tick,
    output logic pull_low
);
    localparam int HC_W = $clog2(HOLD_TICKS + 1);
    localparam logic [HC_W-1:0] LAST = HC_W'(HOLD_TICKS - 1);

    rp_state_t       st, st_nxt;
    logic [HC_W-1:0] hcnt;

    always_comb begin
        st_nxt = st;
        unique case (st)
            RP_RELEASE: if (expire) st_nxt = RP_HOLD;
            RP_HOLD:    if (!expire && tick && hcnt == LAST) st_nxt = RP_RELEASE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RP_RELEASE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    hcnt <= '0;
        else if (expire)               hcnt <= '0;
        else if (st == RP_HOLD && tick) hcnt <= hcnt + HC_W'(1);
    end

    always_comb pull_low = (st == RP_HOLD);

    // R11
    pull_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_low) |-> $past(expire));
    // R11
    pull_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_low) |-> $past(tick));
endmodule

// File: rtl/fsel_select.sv
module fsel_select #(
    parameter int SEL_W = 5,
    parameter int FS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             pin_pair5,
    input  logic             pin_c24,
    input  logic [FS_W-1:0]  latched_fs,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_code,
    input  logic             sel_sw_en,
    input  logic             sel_stepless,
    input  logic             safe_en,
    input  logic [SEL_W-1:0] safe_code,
    input  logic             expire,
    input  logic             c24_wr,
    input  logic             c24_val,
    input  logic             pair5_wr,
    input  logic             pair5_val,
    output logic [SEL_W-1:0] table_idx,
    output logic             mn_mode,
    output logic             c24_sel,
    output logic             pair5_cpu
);
    localparam int PAD_W = SEL_W - FS_W;

    logic [SEL_W-1:0] ssel;
    logic             sw_en;
    logic             stepless;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ssel     <= '0;
            sw_en    <= 1'b0;
            stepless <= 1'b0;
        end else if (expire) begin
            stepless <= 1'b0;
            if (safe_en) begin
                ssel  <= safe_code;
                sw_en <= 1'b1;
            end else begin
                sw_en <= 1'b0;
            end
        end else if (sel_wr) begin
            ssel     <= sel_code;
            sw_en    <= sel_sw_en;
            stepless <= sel_stepless;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c24_sel   <= 1'b0;
            pair5_cpu <= 1'b0;
        end else if (capture) begin
            c24_sel   <= pin_c24;
            pair5_cpu <= pin_pair5;
        end else begin
            if (c24_wr)   c24_sel   <= c24_val;
            if (pair5_wr) pair5_cpu <= pair5_val;
        end
    end

    always_comb begin
        table_idx = sw_en ? ssel : {{PAD_W{1'b0}}, latched_fs};
        mn_mode   = stepless;
    end

    // R9
    expire_clears_mn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !mn_mode);
    // R12
    expire_safe_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && safe_en) |=> (table_idx == $past(safe_code)));
    // R10
    expire_strap_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !safe_en) |=> (table_idx[FS_W-1:0] == latched_fs));
endmodule

// File: rtl/fsel_wdog_top.sv
module fsel_wdog_top #(
    parameter int SEL_W      = 5,
    parameter int FS_W       = 3,
    parameter int CNT_W      = 7,
    parameter int CNT_RST    = 8,
    parameter int RST_TICKS  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwrgd_n,
    input  logic [FS_W-1:0]  strap_fsel,
    input  logic             strap_pair5,
    input  logic             strap_c24,
    input  logic             tick_250ms,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_code,
    input  logic             sel_sw_en,
    input  logic             sel_stepless,
    input  logic             safe_en,
    input  logic [SEL_W-1:0] safe_code,
    input  logic             wd_en_wr,
    input  logic             wd_en_val,
    input  logic             wd_cnt_wr,
    input  logic [CNT_W-1:0] wd_cnt_val,
    input  logic             c24_wr,
    input  logic             c24_val,
    input  logic             pair5_wr,
    input  logic             pair5_val,
    output logic [SEL_W-1:0] table_idx,
    output logic             mn_mode,
    output logic [FS_W-1:0]  latched_fs,
    output logic             strap_done,
    output logic             wd_running,
    output logic [CNT_W-1:0] wd_count,
    output logic             wd_expired,
    output logic             rst_pull_low,
    output logic             c24_sel,
    output logic             pair5_cpu
);
    logic capture;
    logic expire;

    fsel_strap #(.FS_W(FS_W)) u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwrgd_n (pwrgd_n),
        .pins    (strap_fsel),
        .capture (capture),
        .done    (strap_done),
        .latched (latched_fs)
    );

    fsel_wdog #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_250ms),
        .en_wr   (wd_en_wr),
        .en_val  (wd_en_val),
        .cnt_wr  (wd_cnt_wr),
        .cnt_val (wd_cnt_val),
        .running (wd_running),
        .count   (wd_count),
        .flag    (wd_expired),
        .expire  (expire)
    );

    fsel_rstgen #(.HOLD_TICKS(RST_TICKS)) u_rstgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .tick     (tick_250ms),
        .pull_low (rst_pull_low)
    );

    fsel_select #(.SEL_W(SEL_W), .FS_W(FS_W)) u_select (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (capture),
        .pin_pair5    (strap_pair5),
        .pin_c24      (strap_c24),
        .latched_fs   (latched_fs),
        .sel_wr       (sel_wr),
        .sel_code     (sel_code),
        .sel_sw_en    (sel_sw_en),
        .sel_stepless (sel_stepless),
        .safe_en      (safe_en),
        .safe_code    (safe_code),
        .expire       (expire),
        .c24_wr       (c24_wr),
        .c24_val      (c24_val),
        .pair5_wr     (pair5_wr),
        .pair5_val    (pair5_val),
        .table_idx    (table_idx),
        .mn_mode      (mn_mode),
        .c24_sel      (c24_sel),
        .pair5_cpu    (pair5_cpu)
    );

    // R5
    arm_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_running && !wd_cnt_wr) |=> (wd_count == $past(wd_count)));
endmodule

// File: tb/fsel_wdog_tb.sv
module fsel_wdog_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwrgd_n = 1'b1;
    logic [2:0] strap_fsel = 3'b101;
    logic       strap_pair5 = 1'b1;
    logic       strap_c24 = 1'b1;
    logic       tick_250ms = 1'b0;
    logic       sel_wr = 1'b0;
    logic [4:0] sel_code = '0;
    logic       sel_sw_en = 1'b0;
    logic       sel_stepless = 1'b0;
    logic       safe_en = 1'b0;
    logic [4:0] safe_code = '0;
    logic       wd_en_wr = 1'b0;
    logic       wd_en_val = 1'b0;
    logic       wd_cnt_wr = 1'b0;
    logic [6:0] wd_cnt_val = '0;
    logic       c24_wr = 1'b0;
    logic       c24_val = 1'b0;
    logic       pair5_wr = 1'b0;
    logic       pair5_val = 1'b0;
    logic [4:0] table_idx;
    logic       mn_mode;
    logic [2:0] latched_fs;
    logic       strap_done;
    logic       wd_running;
    logic [6:0] wd_count;
    logic       wd_expired;
    logic       rst_pull_low;
    logic       c24_sel;
    logic       pair5_cpu;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fsel_wdog_top dut_i (
        .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .strap_fsel(strap_fsel),
        .strap_pair5(strap_pair5), .strap_c24(strap_c24), .tick_250ms(tick_250ms),
        .sel_wr(sel_wr), .sel_code(sel_code), .sel_sw_en(sel_sw_en),
        .sel_stepless(sel_stepless), .safe_en(safe_en), .safe_code(safe_code),
        .wd_en_wr(wd_en_wr), .wd_en_val(wd_en_val), .wd_cnt_wr(wd_cnt_wr),
        .wd_cnt_val(wd_cnt_val), .c24_wr(c24_wr), .c24_val(c24_val),
        .pair5_wr(pair5_wr), .pair5_val(pair5_val), .table_idx(table_idx),
        .mn_mode(mn_mode), .latched_fs(latched_fs), .strap_done(strap_done),
        .wd_running(wd_running), .wd_count(wd_count), .wd_expired(wd_expired),
        .rst_pull_low(rst_pull_low), .c24_sel(c24_sel), .pair5_cpu(pair5_cpu)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one clock edge passes; strobes drop afterwards
    task automatic cyc();
        @(negedge clk);
        tick_250ms = 1'b0; sel_wr = 1'b0; wd_en_wr = 1'b0;
        wd_cnt_wr = 1'b0; c24_wr = 1'b0; pair5_wr = 1'b0;
    endtask

    task automatic do_tick();
        tick_250ms = 1'b1; cyc();
    endtask

    task automatic do_sel(input logic [4:0] code, input logic sw, input logic sl);
        sel_wr = 1'b1; sel_code = code; sel_sw_en = sw; sel_stepless = sl; cyc();
    endtask

    task automatic do_en(input logic v);
        wd_en_wr = 1'b1; wd_en_val = v; cyc();
    endtask

    task automatic do_cnt(input logic [6:0] v);
        wd_cnt_wr = 1'b1; wd_cnt_val = v; cyc();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        chk("R2", "idx after reset", int'(table_idx), 0);
        chk("R3", "mn after reset", int'(mn_mode), 0);
        chk("R6", "count reset", int'(wd_count), 8);
        chk("R5", "running reset", int'(wd_running), 0);
        chk("R7", "flag reset", int'(wd_expired), 0);
        chk("R11", "pull reset", int'(rst_pull_low), 0);
        chk("R1", "done before pg", int'(strap_done), 0);
        chk("R4", "c24 reset", int'(c24_sel), 0);
    endtask

    task automatic t_strap();
        pwrgd_n = 1'b0; cyc();
        chk("R1", "latched fs", int'(latched_fs), 5);
        chk("R1", "done", int'(strap_done), 1);
        chk("R2", "hw idx", int'(table_idx), 5);
        chk("R4", "c24 from strap", int'(c24_sel), 1);
        chk("R4", "pair5 from strap", int'(pair5_cpu), 1);
        strap_fsel = 3'b010; strap_c24 = 1'b0; pwrgd_n = 1'b1; cyc();
        pwrgd_n = 1'b0; cyc(); cyc();
        chk("R1", "fs ignored later", int'(latched_fs), 5);
        chk("R4", "c24 kept", int'(c24_sel), 1);
    endtask

    task automatic t_select();
        do_sel(5'h13, 1'b1, 1'b0);
        chk("R2", "sw idx", int'(table_idx), 8'h13);
        do_sel(5'h1F, 1'b0, 1'b0);
        chk("R2", "hw idx back", int'(table_idx), 5);
        do_sel(5'h07, 1'b1, 1'b1);
        chk("R3", "mn on", int'(mn_mode), 1);
        chk("R3", "idx with mn", int'(table_idx), 7);
        c24_wr = 1'b1; c24_val = 1'b0; cyc();
        chk("R4", "c24 write", int'(c24_sel), 0);
        pair5_wr = 1'b1; pair5_val = 1'b0; cyc();
        chk("R4", "pair5 write", int'(pair5_cpu), 0);
    endtask

    task automatic t_wd_safe();
        safe_en = 1'b1; safe_code = 5'h0A;
        do_en(1'b1);
        chk("R5", "running armed", int'(wd_running), 1);
        do_tick();
        chk("R5", "armed no move", int'(wd_count), 8);
        do_cnt(7'd3);
        chk("R6", "loaded", int'(wd_count), 3);
        do_tick();
        chk("R6", "dec 2", int'(wd_count), 2);
        do_tick();
        chk("R6", "dec 1", int'(wd_count), 1);
        chk("R6", "running", int'(wd_running), 1);
        do_tick();
        chk("R7", "count zero", int'(wd_count), 0);
        chk("R7", "running off", int'(wd_running), 0);
        chk("R7", "flag set", int'(wd_expired), 1);
        chk("R9", "mn cleared", int'(mn_mode), 0);
        chk("R9", "safe idx", int'(table_idx), 8'h0A);
        chk("R11", "pull start", int'(rst_pull_low), 1);
        cyc(); cyc();
        chk("R11", "pull held", int'(rst_pull_low), 1);
        do_tick();
        chk("R11", "pull release", int'(rst_pull_low), 0);
        chk("R7", "flag sticky", int'(wd_expired), 1);
    endtask

    task automatic t_wd_strap();
        safe_en = 1'b0;
        do_sel(5'h11, 1'b1, 1'b1);
        chk("R3", "mn on again", int'(mn_mode), 1);
        do_en(1'b1);
        do_cnt(7'd2);
        do_tick();
        do_tick();
        chk("R10", "strap idx", int'(table_idx), 5);
        chk("R9", "mn cleared 2", int'(mn_mode), 0);
        do_tick();
        chk("R11", "pull release 2", int'(rst_pull_low), 0);
    endtask

    task automatic t_reload_stop();
        do_en(1'b1);
        do_cnt(7'd4);
        chk("R8", "flag cleared", int'(wd_expired), 0);
        do_tick();
        chk("R6", "dec 3", int'(wd_count), 3);
        do_cnt(7'd6);
        chk("R8", "reload", int'(wd_count), 6);
        tick_250ms = 1'b1; do_cnt(7'd5);
        chk("R8", "write beats tick", int'(wd_count), 5);
        do_en(1'b0);
        chk("R13", "stopped", int'(wd_running), 0);
        do_tick();
        chk("R13", "count held", int'(wd_count), 5);
        chk("R13", "no pull", int'(rst_pull_low), 0);
        do_cnt(7'd2);
        chk("R5", "idle load", int'(wd_count), 2);
        do_tick();
        chk("R5", "idle no start", int'(wd_count), 2);
        chk("R5", "idle running", int'(wd_running), 0);
    endtask

    task automatic t_collision();
        safe_en = 1'b1; safe_code = 5'h0C;
        do_en(1'b1);
        do_cnt(7'd1);
        tick_250ms = 1'b1; do_sel(5'h03, 1'b1, 1'b1);
        chk("R12", "expiry wins idx", int'(table_idx), 8'h0C);
        chk("R12", "expiry wins mn", int'(mn_mode), 0);
        chk("R12", "pull on", int'(rst_pull_low), 1);
        do_tick();
        chk("R11", "pull release 3", int'(rst_pull_low), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_strap();
        t_select();
        t_wd_safe();
        t_wd_strap();
        t_reload_stop();
        t_collision();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule